// File: doc/BRIEF.md
# Add-One Carry Select Adder

This block is a purely combinational binary adder. It takes two operands of `WIDTH` bits and a carry-in, and returns a `WIDTH`-bit sum and a carry-out. The word is split into 4-bit groups.

The lowest group is a plain ripple chain that takes the external carry-in directly. Each higher group computes one result straight away, with an assumed incoming carry of zero. This result is the 4-bit sum plus the group carry, five bits in all. A 5-bit increment stage derives the alternative result for an incoming carry of one from that value. A 2:1 selector, driven by the real carry from the group below, then picks one of the two results.

Both candidate results of every group form as soon as the operands settle. Only the final pick waits on the carry arriving from below. The same group structure builds adders of 8, 16, 32 or 64 bits. A `WIDTH` that is not a multiple of 4, or that is below 8, stops elaboration with an error.

Top module: `addone_csel_adder`

## Requirements
- R1: For every operand pair and carry-in, `sum` equals the low `WIDTH` bits of a + b + cin.
- R2: `cout` equals bit `WIDTH` of a + b + cin. For example, at 8 bits 0x80 + 0x80 gives sum 0x00 and cout 1.
- R3: The external carry-in enters at bit 0 of the lowest group. At 8 bits, 0 + 0 + 1 gives sum 0x01 and cout 0.
- R4: The increment stage maps its 5-bit input v to (v + 1) mod 32. A group whose zero-carry sum is 1111, with group carry 0, becomes 0000 with an outgoing carry of 1 when the carry from below is 1. At 8 bits, 0xF8 + 0x08 gives sum 0x00 and cout 1.
- R5: A group whose incoming carry is 0 yields the 4-bit sum of its operand bits. A group whose incoming carry is 1 yields that sum plus one. At 8 bits, 0x34 + 0x12 = 0x46, and 0x35 + 0x1B = 0x50.
- R6: A carry entering at bit 0 travels through every group. An all-ones operand plus zero with cin 1 gives sum 0 and cout 1.
- R7: All-ones plus all-ones gives all-ones less its bit 0 with cin 0, and all-ones with cin 1, in both cases with cout 1. An alternating 1010 pattern plus 0101 gives all-ones with cout 0 for cin 0, and zero with cout 1 for cin 1.
- R8: The same structure built at 8, 32 and 64 bits meets R1 and R2 at each width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top group |

## Verification
There are no registers in the block, so sum and cout are due in the same cycle as the operands, zero clock edges later. The bench changes the inputs and waits 2 ns, well inside one 8 ns period, before it compares the outputs. No clock edge ever separates a stimulus from its check.

The 8-bit build is checked exhaustively. The 32-bit and 64-bit builds are checked with a table of corner vectors and random operands, all compared against an arithmetic reference in the bench.

// File: rtl/addsel_pkg.sv
package addsel_pkg;
  // Bits per select group; the increment stage is one bit wider.
  localparam int GRP_W = 4;
  localparam int INC_W = GRP_W + 1;
endpackage

// File: rtl/addsel_fa.sv
module addsel_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = x ^ y;
  assign s  = p ^ ci;
  assign co = (x & y) | (p & ci);
endmodule

// File: rtl/addsel_ripple.sv
module addsel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    addsel_fa u_fa (
      .x (x[i]),
      .y (y[i]),
      .ci(c[i]),
      .s (s[i]),
      .co(c[i+1])
    );
  end

  assign co = c[W];

  // R1: the chain of cells forms the arithmetic sum of its inputs
  always_comb begin
    a_r1_ripple_sum: assert ({co, s} == {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci})
      else $error("ripple chain sum mismatch");
  end
endmodule

// File: rtl/addsel_inc.sv
module addsel_inc #(
  parameter int W = 5
) (
  input  logic [W-1:0] v,
  output logic [W-1:0] q
);
  // Bit i flips when every bit below it is one.
  assign q[0] = ~v[0];
  for (genvar i = 1; i < W; i++) begin : g_bit
    assign q[i] = v[i] ^ (&v[i-1:0]);
  end

  // R4: output is the input plus one, wrapping at the top
  always_comb begin
    a_r4_inc_wrap: assert (q == W'(v + W'(1)))
      else $error("increment stage mismatch");
  end
endmodule

// File: rtl/addsel_group.sv
module addsel_group
  import addsel_pkg::*;
(
  input  logic [GRP_W-1:0] x,
  input  logic [GRP_W-1:0] y,
  input  logic             ci,
  output logic [GRP_W-1:0] s,
  output logic             co
);
  logic [GRP_W-1:0] s_zero;
  logic             c_zero;
  logic [INC_W-1:0] r_zero;
  logic [INC_W-1:0] r_one;
  logic [INC_W-1:0] r_pick;

  // Candidate for an incoming carry of zero.
  addsel_ripple #(.W(GRP_W)) u_chain (
    .x (x),
    .y (y),
    .ci(1'b0),
    .s (s_zero),
    .co(c_zero)
  );

  assign r_zero = {c_zero, s_zero};

  // Candidate for an incoming carry of one.
  addsel_inc #(.W(INC_W)) u_inc (
    .v(r_zero),
    .q(r_one)
  );

  assign r_pick = ci ? r_one : r_zero;
  assign s      = r_pick[GRP_W-1:0];
  assign co     = r_pick[GRP_W];

  // R5: the selected result is the group sum including the real carry
  always_comb begin
    a_r5_group_pick: assert ({co, s} == {1'b0, x} + {1'b0, y} + {{GRP_W{1'b0}}, ci})
      else $error("group selection mismatch");
  end

  // R4: a zero-carry result can never overflow five bits, so the increment never wraps
  always_comb begin
    a_r4_no_wrap: assert (r_zero != {INC_W{1'b1}})
      else $error("group candidate out of range");
  end
endmodule

// File: rtl/addone_csel_adder.sv
module addone_csel_adder
  import addsel_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = WIDTH / GRP_W;

  if ((WIDTH % GRP_W) != 0 || WIDTH < 2 * GRP_W) begin : g_bad_width
    $error("addone_csel_adder: WIDTH must be a multiple of 4 and at least 8");
  end

  logic [NGRP:0] gc;
  assign gc[0] = cin;

  // Lowest group: plain ripple chain on the external carry.
  addsel_ripple #(.W(GRP_W)) u_low (
    .x (a[GRP_W-1:0]),
    .y (b[GRP_W-1:0]),
    .ci(gc[0]),
    .s (sum[GRP_W-1:0]),
    .co(gc[1])
  );

  for (genvar g = 1; g < NGRP; g++) begin : g_grp
    addsel_group u_grp (
      .x (a[g*GRP_W +: GRP_W]),
      .y (b[g*GRP_W +: GRP_W]),
      .ci(gc[g]),
      .s (sum[g*GRP_W +: GRP_W]),
      .co(gc[g+1])
    );
  end

  assign cout = gc[NGRP];

  // R1, R2: whole-word result against the arithmetic sum
  always_comb begin
    a_r1_word_sum: assert ({cout, sum} == {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})
      else $error("adder word mismatch");
  end

  // R6: all-ones plus zero with a carry in wraps fully and carries out
  always_comb begin
    if (a == {WIDTH{1'b1}} && b == '0 && cin) begin
      a_r6_full_carry: assert (sum == '0 && cout)
        else $error("full carry propagation failed");
    end
  end
endmodule

// File: tb/tb_addone_csel_adder.sv
module tb_addone_csel_adder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0]  a8,  b8,  s8;   logic c8,  co8;
  logic [31:0] a32, b32, s32;  logic c32, co32;
  logic [63:0] a64, b64, s64;  logic c64, co64;

  addone_csel_adder #(.WIDTH(8)) dut (
    .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));
  addone_csel_adder #(.WIDTH(32)) dut_w32 (
    .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));
  addone_csel_adder #(.WIDTH(64)) dut_w64 (
    .a(a64), .b(b64), .cin(c64), .sum(s64), .cout(co64));

  localparam int NVEC = 12;
  localparam logic [128:0] VEC [NVEC] = '{
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0},
    {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1},
    {64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0},
    {64'h0, 64'h0, 1'b0},
    {64'h0, 64'h0, 1'b1},
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
    {64'h0FFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0010, 1'b0},
    {64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1},
    {64'h1234_5678_9ABC_DEF0, 64'hEDCB_A987_6543_210F, 1'b1}
  };

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run8(input logic [7:0] x, input logic [7:0] y, input logic ci,
                      input string req, input logic [8:0] exp);
    a8 = x; b8 = y; c8 = ci;
    #2;
    check(req, {56'h0, co8, s8}, {56'h0, exp});
  endtask

  task automatic run64(input logic [63:0] x, input logic [63:0] y, input logic ci,
                       input string req);
    logic [64:0] ref64;
    a64 = x; b64 = y; c64 = ci;
    ref64 = {1'b0, x} + {1'b0, y} + {64'h0, ci};
    #2;
    check(req, {co64, s64}, ref64);
  endtask

  task automatic run32(input logic [31:0] x, input logic [31:0] y, input logic ci);
    logic [32:0] ref32;
    a32 = x; b32 = y; c32 = ci;
    ref32 = {1'b0, x} + {1'b0, y} + {32'h0, ci};
    #2;
    check("R8 w32", {32'h0, co32, s32}, {32'h0, ref32});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    a64 = '0; b64 = '0; c64 = 1'b0;
    @(negedge clk);
    // Idle state: zero inputs give zero outputs (R1)
    check("R1 idle", {56'h0, co8, s8}, 65'h0);

    // Corner table at 64 bits (R6, R7, R8)
    for (int i = 0; i < NVEC; i++) begin
      run64(VEC[i][128:65], VEC[i][64:1], VEC[i][0], "R8 R6 R7 table");
    end

    // Directed cases at 8 bits
    run8(8'h00, 8'h00, 1'b1, "R3", 9'h001);
    run8(8'h80, 8'h80, 1'b0, "R2", 9'h100);
    run8(8'hF8, 8'h08, 1'b0, "R4", 9'h100);
    run8(8'h34, 8'h12, 1'b0, "R5 carry0", 9'h046);
    run8(8'h35, 8'h1B, 1'b0, "R5 carry1", 9'h050);
    run8(8'hFF, 8'h00, 1'b1, "R6", 9'h100);
    run8(8'hFF, 8'hFF, 1'b0, "R7 ones cin0", 9'h1FE);
    run8(8'hFF, 8'hFF, 1'b1, "R7 ones cin1", 9'h1FF);
    run8(8'hAA, 8'h55, 1'b0, "R7 alt cin0", 9'h0FF);
    run8(8'hAA, 8'h55, 1'b1, "R7 alt cin1", 9'h100);

    // Directed 64-bit corners with hand values (R6, R7)
    a64 = '1; b64 = '0; c64 = 1'b1; #2;
    check("R6 w64", {co64, s64}, {1'b1, 64'h0});
    a64 = 64'hAAAA_AAAA_AAAA_AAAA; b64 = 64'h5555_5555_5555_5555; c64 = 1'b0; #2;
    check("R7 w64 alt", {co64, s64}, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});

    // Exhaustive 8-bit (R1, R2)
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        for (int k = 0; k < 2; k++) begin
          run8(i[7:0], j[7:0], k[0], "R1 R2 exhaustive",
               9'(i) + 9'(j) + 9'(k));
        end
      end
    end

    // Random at 32 and 64 bits (R8)
    for (int i = 0; i < 2000; i++) begin
      run32($urandom, $urandom, 1'($urandom));
      run64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R8 w64 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule